// File: doc/BRIEF.md
# Bus Address Breakpoint Interrupt Unit

This unit sits beside a CPU with a 24-bit address bus. It watches every bus cycle and, when armed, drives a one-clock active-low interrupt request to the CPU's non-maskable interrupt input whenever the address of a cycle equals a programmed breakpoint address. A debug monitor can use this to trap execution or data access at one chosen location without halting the processor.

Software programs the breakpoint through a reserved 256-byte window at the very top of the address space, FFFF00h to FFFFFFh. This window lies inside the extended I/O region that starts at F00000h. The 24-bit breakpoint is written one byte at a time over the 8-bit data bus, and a separate arm bit turns matching on or off. A write into the window only programs the unit: it is never compared against the breakpoint.

A bus cycle starts on the first clock in which the address strobe is seen low after it has been high. Address, data and the write strobe are taken on that clock. Holding the strobe low for more clocks does not start another cycle.

Top module: `brkpt_nmi_unit`

## Requirements
- R1: After reset the interrupt output is high, the unit is disarmed and the breakpoint register holds 000000h.
- R2: A bus cycle starts only on a clock where the address strobe is low and it was high on the clock before. Two cycles never start on consecutive clocks.
- R3: A write cycle in the window at offset 00h loads breakpoint bits 23:16 from the data bus. Offset 01h loads bits 15:8 and offset 02h loads bits 7:0.
- R4: A write cycle in the window at offset 03h sets the arm state to data bit 0 (1 = armed, 0 = disarmed).
- R5: Window writes at offsets 04h to FFh, and read cycles anywhere in the window, leave the breakpoint and the arm state unchanged.
- R6: Write cycles outside FFFF00h to FFFFFFh never change the breakpoint or the arm state. This includes addresses just below the window.
- R7: A read cycle, or a write outside the window, whose address equals the breakpoint while armed drives the interrupt output low for exactly one clock. That clock is the one after the edge where the cycle starts.
- R8: When the unit is disarmed, or the address differs from the breakpoint, the interrupt output stays high.
- R9: A write cycle into the window never drives the interrupt output low, even if its address equals the breakpoint.
- R10: An address strobe held low over several clocks gives at most one interrupt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 24 | CPU address bus |
| bus_data | input | 8 | CPU write data bus |
| bus_wr_n | input | 1 | Write strobe, low for a write cycle |
| bus_as_n | input | 1 | Address strobe, low while a bus cycle is active |
| nmi_n | output | 1 | Non-maskable interrupt request, active low, one clock per match |

## Verification
The interrupt for a cycle is due on the clock right after the rising edge that first samples the strobe low. A register or arm change made by a window write takes effect for the next cycle that starts. The bench drives each cycle on a falling edge and samples the interrupt on the next falling edge. It then checks that the output is high again on every later falling edge while the strobe stays low and one edge after it is released. The effect of every write is judged only through the interrupt response of later probe cycles. The expected response comes from a bench model of the breakpoint and arm state.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_PROG  = 2'd1,
    CYC_PROBE = 2'd2
  } cyc_kind_e;

  // True when addr shares all bits above the window size with base.
  function automatic logic in_window(input logic [31:0] addr,
                                     input logic [31:0] base,
                                     input int unsigned win_bits);
    return (addr >> win_bits) == (base >> win_bits);
  endfunction

  // Byte offset of addr inside its window.
  function automatic logic [31:0] win_offset(input logic [31:0] addr,
                                             input int unsigned win_bits);
    return addr & ((32'd1 << win_bits) - 32'd1);
  endfunction

endpackage

// File: rtl/bus_cycle_detect.sv
module bus_cycle_detect
  import brkpt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter logic [31:0] WIN_BASE = 32'h00FF_FF00,
  parameter int unsigned WIN_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              cyc_start,
  output cyc_kind_e         cyc_kind
);

  logic as_prev_q;
  logic win_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) as_prev_q <= 1'b1;
    else        as_prev_q <= as_n;
  end

  assign cyc_start = !as_n && as_prev_q;
  assign win_hit   = in_window(32'(addr), WIN_BASE, WIN_BITS);

  always_comb begin
    if (!cyc_start)           cyc_kind = CYC_IDLE;
    else if (!wr_n && win_hit) cyc_kind = CYC_PROG;
    else                      cyc_kind = CYC_PROBE;
  end

  // R2
  no_back_to_back_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start);

endmodule

// File: rtl/brk_regfile.sv
module brk_regfile
  import brkpt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned WIN_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [ADDR_W-1:0] brk_addr,
  output logic              armed
);

  localparam int unsigned NBYTES = ADDR_W / DATA_W;
  localparam int unsigned EN_OFF = NBYTES;

  logic [31:0] offset;
  logic        arm_wr;

  assign offset = win_offset(32'(addr), WIN_BITS);
  assign arm_wr = prog_evt && (offset == 32'(EN_OFF));

  // Offset 0 holds the most significant byte.
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic [DATA_W-1:0] byte_q;
    logic              byte_wr;
    assign byte_wr = prog_evt && (offset == 32'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)       byte_q <= '0;
      else if (byte_wr) byte_q <= data;
    end
    assign brk_addr[(NBYTES-1-i)*DATA_W +: DATA_W] = byte_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      armed <= 1'b0;
    else if (arm_wr) armed <= data[0];
  end

  // R5
  hold_without_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_evt |=> ($stable(brk_addr) && $stable(armed)));

  // R4
  arm_follows_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_wr |=> (armed == $past(data[0])));

endmodule

// File: rtl/brk_compare.sv
module brk_compare
  import brkpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_kind_e         cyc_kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] brk_addr,
  input  logic              armed,
  output logic              nmi_n,
  output logic              hit
);

  assign hit = (cyc_kind == CYC_PROBE) && armed && (addr == brk_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) nmi_n <= 1'b1;
    else        nmi_n <= !hit;
  end

  // R7
  single_clock_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_n |=> nmi_n);

  // R9
  prog_never_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == CYC_PROG) |=> nmi_n);

  // R8
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc_kind == CYC_PROBE) && !armed) |=> nmi_n);

endmodule

// File: rtl/brkpt_nmi_unit.sv
module brkpt_nmi_unit
  import brkpt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DATA_W   = 8,
  parameter logic [31:0] WIN_BASE = 32'h00FF_FF00,
  parameter int unsigned WIN_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_wr_n,
  input  logic              bus_as_n,
  output logic              nmi_n
);

  logic              cyc_start;
  cyc_kind_e         cyc_kind;
  logic              prog_evt;
  logic [ADDR_W-1:0] brk_addr;
  logic              armed;
  logic              hit;

  bus_cycle_detect #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS)
  ) u_detect (
    .clk(clk), .rst_n(rst_n), .as_n(bus_as_n), .wr_n(bus_wr_n),
    .addr(bus_addr), .cyc_start(cyc_start), .cyc_kind(cyc_kind)
  );

  assign prog_evt = (cyc_kind == CYC_PROG);

  brk_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .prog_evt(prog_evt), .addr(bus_addr),
    .data(bus_data), .brk_addr(brk_addr), .armed(armed)
  );

  brk_compare #(
    .ADDR_W(ADDR_W)
  ) u_cmp (
    .clk(clk), .rst_n(rst_n), .cyc_kind(cyc_kind), .addr(bus_addr),
    .brk_addr(brk_addr), .armed(armed), .nmi_n(nmi_n), .hit(hit)
  );

  // R10
  held_strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && !$past(bus_as_n)) |=> nmi_n);

  // R7
  pulse_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_n) |-> $past(cyc_start));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (nmi_n && !armed && (brk_addr == '0)));

endmodule

// File: tb/brkpt_nmi_unit_tb.sv
module brkpt_nmi_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        bus_wr_n = 1'b1;
  logic        bus_as_n = 1'b1;
  logic        nmi_n;

  int n_checks = 0;
  int n_fails  = 0;

  logic [23:0] m_brk = 24'h0;
  logic        m_armed = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  brkpt_nmi_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_wr_n(bus_wr_n), .bus_as_n(bus_as_n), .nmi_n(nmi_n)
  );

  function automatic logic tb_in_win(input logic [23:0] a);
    return a[23:8] == 16'hFFFF;
  endfunction

  function automatic logic tb_expect_nmi(input logic [23:0] a, input logic wr);
    if (wr && tb_in_win(a)) return 1'b0;
    return m_armed && (a == m_brk);
  endfunction

  task automatic tb_model_update(input logic [23:0] a, input logic [7:0] d, input logic wr);
    if (wr && tb_in_win(a)) begin
      case (a[7:0])
        8'h00: m_brk[23:16] = d;
        8'h01: m_brk[15:8]  = d;
        8'h02: m_brk[7:0]   = d;
        8'h03: m_armed      = d[0];
        default: ;
      endcase
    end
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: nmi_n actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // One bus cycle; nmi_n is checked one clock after the strobe is sampled,
  // then while the strobe is held, then once after release.
  task automatic bus_op(input logic [23:0] a, input logic [7:0] d, input logic wr,
                        input int hold, input string tag);
    logic exp_fire;
    exp_fire = tb_expect_nmi(a, wr);
    @(negedge clk);
    bus_addr = a; bus_data = d; bus_wr_n = !wr; bus_as_n = 1'b0;
    @(negedge clk);
    check(tag, nmi_n, !exp_fire);
    tb_model_update(a, d, wr);
    for (int k = 1; k < hold; k++) begin
      @(negedge clk);
      check("R10", nmi_n, 1'b1);
    end
    bus_as_n = 1'b1; bus_wr_n = 1'b1;
    @(negedge clk);
    check("R7", nmi_n, 1'b1);
  endtask

  task automatic set_brk(input logic [23:0] v);
    bus_op(24'hFFFF00, v[23:16], 1'b1, 1, "R3");
    bus_op(24'hFFFF01, v[15:8],  1'b1, 1, "R3");
    bus_op(24'hFFFF02, v[7:0],   1'b1, 1, "R3");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", nmi_n, 1'b1);

    // R1: disarmed after reset, register zero
    bus_op(24'h000000, 8'h00, 1'b0, 1, "R1");
    bus_op(24'hFFFF03, 8'h01, 1'b1, 1, "R4");
    bus_op(24'h000000, 8'h00, 1'b0, 1, "R1");

    // R3: byte loads, then exact and near-miss probes
    set_brk(24'h123456);
    bus_op(24'h123456, 8'h00, 1'b0, 1, "R3");
    bus_op(24'h123457, 8'h00, 1'b0, 1, "R8");
    bus_op(24'h923456, 8'h00, 1'b0, 1, "R8");

    // R5: unused offsets and reads in window are ignored
    bus_op(24'hFFFF07, 8'hAB, 1'b1, 1, "R5");
    bus_op(24'hFFFF40, 8'hCD, 1'b1, 1, "R5");
    bus_op(24'hFFFF00, 8'h77, 1'b0, 1, "R5");
    bus_op(24'hFFFF03, 8'h00, 1'b0, 1, "R5");
    bus_op(24'h123456, 8'h00, 1'b1, 1, "R5");

    // R4: disarm by bit0 = 0 with other bits set
    bus_op(24'hFFFF03, 8'hFE, 1'b1, 1, "R4");
    bus_op(24'h123456, 8'h00, 1'b0, 1, "R4");

    // R6: writes just below and far from the window
    bus_op(24'hFFFEFF, 8'h01, 1'b1, 1, "R6");
    bus_op(24'hFEFF03, 8'h01, 1'b1, 1, "R6");
    bus_op(24'h123456, 8'h00, 1'b0, 1, "R6");
    bus_op(24'hFFFF03, 8'h01, 1'b1, 1, "R4");
    bus_op(24'hFFFE00, 8'h99, 1'b1, 1, "R6");
    bus_op(24'h123456, 8'h00, 1'b0, 1, "R6");

    // R9: breakpoint inside the window
    set_brk(24'hFFFF00);
    bus_op(24'hFFFF00, 8'h00, 1'b0, 1, "R7");
    bus_op(24'hFFFF00, 8'hFF, 1'b1, 1, "R9");

    // R10: held strobe on a match
    set_brk(24'hABCDEF);
    bus_op(24'hABCDEF, 8'h00, 1'b0, 4, "R10");
    bus_op(24'hABCDEF, 8'h00, 1'b1, 3, "R7");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [23:0] a;
      logic [7:0]  d;
      logic        wr;
      int          sel;
      string       tag;
      sel = int'($urandom_range(0, 9));
      d   = 8'($urandom);
      wr  = 1'($urandom);
      if (sel < 3)      a = m_brk;
      else if (sel < 5) a = {16'hFFFF, 8'($urandom_range(0, 5))};
      else if (sel < 6) a = m_brk ^ (24'h1 << $urandom_range(0, 23));
      else              a = 24'($urandom);
      if (wr && tb_in_win(a))                         tag = "R9";
      else if (wr)                                     tag = "R6";
      else if (tb_expect_nmi(a, wr))                   tag = "R7";
      else                                             tag = "R8";
      bus_op(a, d, wr, int'($urandom_range(1, 3)), tag);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule